// File: doc/BRIEF.md
# ATA Task-File Register Device Model

This block is the device side of one ATA channel carrying two drives. A host reaches it through eight byte-wide register offsets: it selects a drive with the device register, loads the sector count and LBA bytes, and starts work by writing a command byte to offset 7. Reads of offset 7 return status. The busy, data-request and error bits in that status carry the handshake the host polls on.

IDENTIFY produces a 256-word block on the 16-bit data port. The block reports the sector total of the drive that was selected, and each drive takes its total from a parameter. DMA commands move no data here. When the device accepts a DMA command it emits a one-cycle acceptance pulse, together with the decoded start address, sector count, direction and drive. The address is decoded from either the 28-bit or the 48-bit register layout. For the 48-bit layout each of offsets 2 to 5 keeps the byte written before the current one.

Top module: `ata_taskfile_dev`

## Requirements
- R1: After reset, status (offset 7) reads 0x40 for a present drive 0; offsets 1 to 6 read 0x00.
- R2: Offsets 2, 3, 4, 5 (count, LBA low, LBA mid, LBA high) and 6 (device) read back the last byte written to them.
- R3: Bit 4 of offset 6 picks drive 0 or 1. If the picked drive's `drv_present` bit is low, status reads 0x00 and a command write is ignored: no busy period and no DMA pulse.
- R4: With both `drv_present` bits low, status reads 0xFF.
- R5: After command 0xEC, status reads 0x80 (bit 7 busy) for exactly BUSY_CYCLES cycles and then 0x48 (bit 6 ready, bit 3 data request).
- R6: The IDENTIFY block is 256 words read at offset 0. Word 0 is 0x0040. Words 60 and 61 hold the selected drive's total, capped at 0x0FFFFFFF, low half first. Words 100 to 103 hold the 48-bit total, low word first. All other words are zero.
- R7: Reading the 256th word drops status to 0x40. Offset 0 then reads 0.
- R8: An unknown command gives status 0x41 (bit 0 error) and 0x04 at offset 1. The next accepted command clears both.
- R9: Commands 0xC8 (read) and 0xCA (write) raise `dma_go` for one cycle after the command edge. They present `dma_lba` = {offset6[3:0], off5, off4, off3}, `dma_count` = off2 and `dma_ext`=0. Status stays 0x40.
- R10: Commands 0x25 (read) and 0x35 (write) present `dma_lba` = {prev5, prev4, prev3, off5, off4, off3} and `dma_count` = {prev2, off2}, with `dma_ext`=1. Here "prev" is the byte written before the current one.
- R11: A command write while status shows busy or data request is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (advances the data port) |
| reg_addr | input | 3 | Register offset 0 to 7 |
| wr_data | input | 8 | Write byte |
| rd_data | output | 16 | Read value of the addressed register |
| drv_present | input | 2 | Per-drive attach flags |
| dma_go | output | 1 | One-cycle DMA acceptance pulse |
| dma_write | output | 1 | Accepted DMA direction, 1 = host to drive |
| dma_ext | output | 1 | Accepted DMA used 48-bit layout |
| dma_drive | output | 1 | Drive of accepted DMA |
| dma_lba | output | 48 | Decoded start LBA |
| dma_count | output | 16 | Decoded sector count |

## Verification
The bench builds the block with BUSY_CYCLES = 3, so it can count every cycle of the busy window by polling. Drive 0 gets a 48-bit total above the 28-bit limit, which exercises the cap in words 60 and 61. Drive 1 gets a small total whose only nonzero part lies in bits 16 and above. This shows that the data port reports the total of whichever drive was selected, and that each half of the total lands in the right word.

// File: rtl/ata_tf_pkg.sv
// Shared constants for the task-file device model: offsets, status bits,
// command codes and controller states.
package ata_tf_pkg;
    localparam int          HIST_REGS   = 4;      // offsets 2..5
    localparam logic [2:0]  OFS_DATA    = 3'd0;
    localparam logic [2:0]  OFS_ERROR   = 3'd1;
    localparam logic [2:0]  OFS_HIST0   = 3'd2;
    localparam logic [2:0]  OFS_DEVICE  = 3'd6;
    localparam logic [2:0]  OFS_CMDSTAT = 3'd7;
    localparam int          DEV_SEL_BIT = 4;

    localparam logic [7:0]  CMD_IDENT   = 8'hEC;
    localparam logic [7:0]  CMD_RD28    = 8'hC8;
    localparam logic [7:0]  CMD_WR28    = 8'hCA;
    localparam logic [7:0]  CMD_RD48    = 8'h25;
    localparam logic [7:0]  CMD_WR48    = 8'h35;
    localparam logic [7:0]  ERR_ABORT   = 8'h04;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUSY = 2'd1,
        ST_XFER = 2'd2
    } ctl_state_t;
endpackage

// File: rtl/ata_tf_regs.sv
// Holds the sector-count/LBA bytes (offsets 2..5) with a one-deep history
// for 48-bit addressing, plus the device register at offset 6.
// Assumes writes arrive as one byte per strobe; writes are taken at any time.
module ata_tf_regs
    import ata_tf_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [2:0]                   wr_addr,
    input  logic [7:0]                   wr_data,
    output logic [HIST_REGS-1:0][7:0]    cur_b,
    output logic [HIST_REGS-1:0][7:0]    prev_b,
    output logic [7:0]                   dev_reg
);
    for (genvar g = 0; g < HIST_REGS; g++) begin : g_hist
        localparam logic [2:0] MY_OFS = OFS_HIST0 + 3'(g);
        // Shift the previous byte down and store the new one on a hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cur_b[g]  <= 8'h00;
                prev_b[g] <= 8'h00;
            end else if (wr_en && wr_addr == MY_OFS) begin
                prev_b[g] <= cur_b[g];
                cur_b[g]  <= wr_data;
            end
        end
    end

    // Device register: drive select and the 28-bit upper nibble.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dev_reg <= 8'h00;
        else if (wr_en && wr_addr == OFS_DEVICE)
            dev_reg <= wr_data;
    end
endmodule

// File: rtl/ata_tf_ident.sv
// Computes one word of the IDENTIFY block from its index and a 48-bit
// sector total. Pure combinational; assumes IDX_W >= 7.
module ata_tf_ident #(
    parameter int IDX_W = 8
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [47:0]      total,
    output logic [15:0]      word
);
    localparam logic [47:0] CAP28 = 48'h0000_0FFF_FFFF;
    logic [27:0] tot28;

    // Clamp the total to what the 28-bit field can express.
    always_comb tot28 = (total > CAP28) ? CAP28[27:0] : total[27:0];

    // Place the fields at their fixed word positions.
    always_comb begin
        case (int'(idx))
            0:       word = 16'h0040;
            60:      word = tot28[15:0];
            61:      word = {4'h0, tot28[27:16]};
            100:     word = total[15:0];
            101:     word = total[31:16];
            102:     word = total[47:32];
            default: word = 16'h0000;
        endcase
    end
endmodule

// File: rtl/ata_tf_ctrl.sv
// Command decoder and status sequencer. Runs IDENTIFY through busy and
// data-request phases, flags unknown commands and latches DMA requests.
// Assumes the caller qualifies cmd_wr with the selected drive being present.
module ata_tf_ctrl
    import ata_tf_pkg::*;
#(
    parameter int BUSY_CYCLES = 4,
    parameter int WORDS       = 256,
    localparam int IDX_W      = $clog2(WORDS),
    localparam int CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cmd_wr,
    input  logic [7:0]                 cmd_byte,
    input  logic                       sel_drive,
    input  logic                       data_rd,
    input  logic [HIST_REGS-1:0][7:0]  cur_b,
    input  logic [HIST_REGS-1:0][7:0]  prev_b,
    input  logic [3:0]                 dev_nib,
    output logic                       st_bsy,
    output logic                       st_drq,
    output logic                       st_err,
    output logic [7:0]                 err_code,
    output logic [IDX_W-1:0]           word_idx,
    output logic                       id_drive,
    output logic                       dma_go,
    output logic                       dma_write,
    output logic                       dma_ext,
    output logic                       dma_drive,
    output logic [47:0]                dma_lba,
    output logic [15:0]                dma_count
);
    ctl_state_t       state;
    logic [CNT_W-1:0] busy_cnt;
    logic             accept;

    always_comb accept = cmd_wr && (state == ST_IDLE);

    // Main sequencer: command decode, busy countdown, word streaming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            busy_cnt <= '0;
            word_idx <= '0;
            st_err   <= 1'b0;
            err_code <= 8'h00;
            id_drive <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (accept) begin
                    st_err   <= 1'b0;
                    err_code <= 8'h00;
                    case (cmd_byte)
                        CMD_IDENT: begin
                            state    <= ST_BUSY;
                            busy_cnt <= CNT_W'(BUSY_CYCLES - 1);
                            id_drive <= sel_drive;
                        end
                        CMD_RD28, CMD_WR28, CMD_RD48, CMD_WR48: ;
                        default: begin
                            st_err   <= 1'b1;
                            err_code <= ERR_ABORT;
                        end
                    endcase
                end
                ST_BUSY: begin
                    if (busy_cnt == '0) begin
                        state    <= ST_XFER;
                        word_idx <= '0;
                    end else begin
                        busy_cnt <= busy_cnt - 1'b1;
                    end
                end
                ST_XFER: if (data_rd) begin
                    if (word_idx == IDX_W'(WORDS - 1))
                        state <= ST_IDLE;
                    else
                        word_idx <= word_idx + 1'b1;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // DMA acceptance: one-cycle pulse and address/count capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_go    <= 1'b0;
            dma_write <= 1'b0;
            dma_ext   <= 1'b0;
            dma_drive <= 1'b0;
            dma_lba   <= '0;
            dma_count <= '0;
        end else begin
            dma_go <= 1'b0;
            if (accept && (cmd_byte == CMD_RD28 || cmd_byte == CMD_WR28)) begin
                dma_go    <= 1'b1;
                dma_write <= (cmd_byte == CMD_WR28);
                dma_ext   <= 1'b0;
                dma_drive <= sel_drive;
                dma_lba   <= {20'h0, dev_nib, cur_b[3], cur_b[2], cur_b[1]};
                dma_count <= {8'h00, cur_b[0]};
            end else if (accept && (cmd_byte == CMD_RD48 || cmd_byte == CMD_WR48)) begin
                dma_go    <= 1'b1;
                dma_write <= (cmd_byte == CMD_WR48);
                dma_ext   <= 1'b1;
                dma_drive <= sel_drive;
                dma_lba   <= {prev_b[3], prev_b[2], prev_b[1], cur_b[3], cur_b[2], cur_b[1]};
                dma_count <= {prev_b[0], cur_b[0]};
            end
        end
    end

    // Status flags decoded from the sequencer state.
    always_comb begin
        st_bsy = (state == ST_BUSY);
        st_drq = (state == ST_XFER);
    end
endmodule

// File: rtl/ata_taskfile_dev.sv
// Top of the task-file device model for one two-drive channel. Routes
// register writes, gates commands on drive presence, and muxes reads.
// Assumes reads have no side effect except at the data offset.
module ata_taskfile_dev
    import ata_tf_pkg::*;
#(
    parameter int          BUSY_CYCLES = 4,
    parameter int          IDENT_WORDS = 256,
    parameter logic [47:0] DRV0_SECTORS = 48'h0000_0100_0000,
    parameter logic [47:0] DRV1_SECTORS = 48'h0000_0080_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [2:0]  reg_addr,
    input  logic [7:0]  wr_data,
    output logic [15:0] rd_data,
    input  logic [1:0]  drv_present,
    output logic        dma_go,
    output logic        dma_write,
    output logic        dma_ext,
    output logic        dma_drive,
    output logic [47:0] dma_lba,
    output logic [15:0] dma_count
);
    localparam int IDX_W = $clog2(IDENT_WORDS);

    logic [HIST_REGS-1:0][7:0] cur_b, prev_b;
    logic [7:0]       dev_reg, err_code, status;
    logic             sel_drive, sel_present, st_bsy, st_drq, st_err, id_drive;
    logic [IDX_W-1:0] word_idx;
    logic [15:0]      id_word;
    logic [47:0]      id_total;

    always_comb begin
        sel_drive   = dev_reg[DEV_SEL_BIT];
        sel_present = drv_present[sel_drive];
        id_total    = id_drive ? DRV1_SECTORS : DRV0_SECTORS;
    end

    ata_tf_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(reg_addr),
        .wr_data(wr_data), .cur_b(cur_b), .prev_b(prev_b), .dev_reg(dev_reg)
    );

    ata_tf_ctrl #(.BUSY_CYCLES(BUSY_CYCLES), .WORDS(IDENT_WORDS)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_wr(wr_en && reg_addr == OFS_CMDSTAT && sel_present),
        .cmd_byte(wr_data), .sel_drive(sel_drive),
        .data_rd(rd_en && reg_addr == OFS_DATA),
        .cur_b(cur_b), .prev_b(prev_b), .dev_nib(dev_reg[3:0]),
        .st_bsy(st_bsy), .st_drq(st_drq), .st_err(st_err), .err_code(err_code),
        .word_idx(word_idx), .id_drive(id_drive),
        .dma_go(dma_go), .dma_write(dma_write), .dma_ext(dma_ext),
        .dma_drive(dma_drive), .dma_lba(dma_lba), .dma_count(dma_count)
    );

    ata_tf_ident #(.IDX_W(IDX_W)) u_ident (
        .idx(word_idx), .total(id_total), .word(id_word)
    );

    // Compose status: floating channel, absent drive, or live flags.
    always_comb begin
        if (drv_present == 2'b00)
            status = 8'hFF;
        else if (!sel_present)
            status = 8'h00;
        else
            status = {st_bsy, ~st_bsy, 2'b00, st_drq, 2'b00, st_err};
    end

    // Read mux across the eight offsets.
    always_comb begin
        case (reg_addr)
            OFS_DATA:    rd_data = st_drq ? id_word : 16'h0000;
            OFS_ERROR:   rd_data = {8'h00, err_code};
            OFS_DEVICE:  rd_data = {8'h00, dev_reg};
            OFS_CMDSTAT: rd_data = {8'h00, status};
            default:     rd_data = {8'h00, cur_b[reg_addr - OFS_HIST0]};
        endcase
    end
endmodule

// File: rtl/ata_taskfile_chk.sv
// Temporal checks on the task-file device model, bound to its top.
module ata_taskfile_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [2:0]  reg_addr,
    input logic [15:0] rd_data,
    input logic [1:0]  drv_present,
    input logic        dma_go,
    input logic        st_bsy,
    input logic        st_drq,
    input logic        st_err
);
    AST_BSY_NOT_DRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_present != 2'b00 && reg_addr == 3'd7 && rd_data[7]) |-> !rd_data[3]); // R5
    AST_BSY_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_bsy) |-> $past(wr_en && reg_addr == 3'd7)); // R5
    AST_DRQ_ENDS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_drq) |-> $past(rd_en && reg_addr == 3'd0)); // R7
    AST_DMA_FROM_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        dma_go |-> $past(wr_en && reg_addr == 3'd7)); // R9
    AST_ERR_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_err |-> (!st_bsy && !st_drq)); // R8
endmodule

bind ata_taskfile_dev ata_taskfile_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .reg_addr(reg_addr), .rd_data(rd_data), .drv_present(drv_present),
    .dma_go(dma_go), .st_bsy(st_bsy), .st_drq(st_drq), .st_err(st_err)
);

// File: tb/ata_taskfile_dev_bench.sv
module ata_taskfile_dev_bench;
    localparam int          BUSY = 3;
    localparam logic [47:0] TOT0 = 48'h0001_2345_6789;
    localparam logic [47:0] TOT1 = 48'h0000_0010_0000;

    logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0]  reg_addr = 3'd7;
    logic [7:0]  wr_data = 8'h00;
    logic [1:0]  drv_present = 2'b11;
    logic [15:0] rd_data;
    logic        dma_go, dma_write, dma_ext, dma_drive;
    logic [47:0] dma_lba;
    logic [15:0] dma_count;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    ata_taskfile_dev #(.BUSY_CYCLES(BUSY), .IDENT_WORDS(256),
                       .DRV0_SECTORS(TOT0), .DRV1_SECTORS(TOT1)) u_ata_taskfile_dev (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .drv_present(drv_present),
        .dma_go(dma_go), .dma_write(dma_write), .dma_ext(dma_ext), .dma_drive(dma_drive),
        .dma_lba(dma_lba), .dma_count(dma_count)
    );

    // Address/data pairs: write then read back (R2).
    localparam logic [10:0] VEC [6] = '{
        {3'd2, 8'h66}, {3'd3, 8'hFF}, {3'd4, 8'h5A},
        {3'd5, 8'hA5}, {3'd6, 8'hB0}, {3'd6, 8'hA0}
    };

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        @(negedge clk);
        rd_en = 1'b1; reg_addr = a;
        #1 v = rd_data;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    function automatic logic [15:0] exp_word(input int i, input logic [47:0] t);
        logic [27:0] c;
        c = (t > 48'h0FFF_FFFF) ? 28'hFFF_FFFF : t[27:0];
        case (i)
            0:   return 16'h0040;
            60:  return c[15:0];
            61:  return {4'h0, c[27:16]};
            100: return t[15:0];
            101: return t[31:16];
            102: return t[47:32];
            default: return 16'h0000;
        endcase
    endfunction

    // Read the full block; check special words and count other mismatches.
    task automatic read_block(input logic [47:0] t);
        logic [15:0] v;
        int bad = 0;
        for (int i = 0; i < 256; i++) begin
            rd(3'd0, v);
            if (i == 0 || i == 60 || i == 61 || i == 100 || i == 101 || i == 102)
                chk($sformatf("R6 word %0d", i), v, exp_word(i, t));
            else if (v !== exp_word(i, t))
                bad++;
        end
        chk("R6 other words zero", bad, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        int busy_n;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        rd(3'd7, v); chk("R1 status", v, 16'h0040);
        for (int a = 1; a <= 6; a++) begin
            rd(3'(a), v); chk($sformatf("R1 offset %0d", a), v, 16'h0000);
        end

        // R2 vector walk
        for (int k = 0; k < 6; k++) begin
            wr(VEC[k][10:8], VEC[k][7:0]);
            rd(VEC[k][10:8], v);
            chk($sformatf("R2 offset %0d", VEC[k][10:8]), v, {8'h00, VEC[k][7:0]});
        end

        // R3 absent selected drive
        drv_present = 2'b01;
        wr(3'd6, 8'hB0);
        rd(3'd7, v); chk("R3 absent status", v, 16'h0000);
        wr(3'd7, 8'hEC);
        wr(3'd7, 8'hC8); chk("R3 no dma pulse", dma_go, 1'b0);
        wr(3'd6, 8'hA0);
        rd(3'd7, v); chk("R3 command ignored", v, 16'h0040);

        // R4 floating channel
        drv_present = 2'b00;
        rd(3'd7, v); chk("R4 floating", v, 16'h00FF);
        drv_present = 2'b11;

        // R5 busy window then data request, drive 0
        wr(3'd7, 8'hEC);
        busy_n = 0;
        rd(3'd7, v);
        while (v == 16'h0080 && busy_n < 50) begin
            busy_n++;
            rd(3'd7, v);
        end
        chk("R5 busy cycles", busy_n, BUSY);
        chk("R5 drq status", v, 16'h0048);
        read_block(TOT0);
        // R7 end of block
        rd(3'd7, v); chk("R7 ready after block", v, 16'h0040);
        rd(3'd0, v); chk("R7 data after block", v, 16'h0000);

        // R11 command during busy ignored; drive 1 block
        wr(3'd6, 8'hB0);
        wr(3'd7, 8'hEC);
        wr(3'd7, 8'h77);
        rd(3'd7, v);
        while (v == 16'h0080) rd(3'd7, v);
        chk("R11 no error from busy write", v, 16'h0048);
        read_block(TOT1);

        // R8 unknown command
        wr(3'd6, 8'hA0);
        wr(3'd7, 8'h77);
        rd(3'd7, v); chk("R8 error status", v, 16'h0041);
        rd(3'd1, v); chk("R8 error code", v, 16'h0004);
        wr(3'd7, 8'hC8);
        rd(3'd7, v); chk("R8 cleared status", v, 16'h0040);
        rd(3'd1, v); chk("R8 cleared code", v, 16'h0000);

        // R9 28-bit DMA write
        wr(3'd6, 8'hE5);
        wr(3'd2, 8'h10); wr(3'd3, 8'h33); wr(3'd4, 8'h22); wr(3'd5, 8'h11);
        wr(3'd7, 8'hCA);
        chk("R9 pulse", dma_go, 1'b1);
        chk("R9 lba", dma_lba, 48'h0000_0511_2233);
        chk("R9 count", dma_count, 16'h0010);
        chk("R9 flags", {dma_write, dma_ext, dma_drive}, 3'b100);
        @(posedge clk); #1;
        chk("R9 pulse one cycle", dma_go, 1'b0);
        rd(3'd7, v); chk("R9 status", v, 16'h0040);

        // R10 48-bit DMA read on drive 1
        wr(3'd6, 8'h50);
        wr(3'd2, 8'h01); wr(3'd3, 8'h44); wr(3'd4, 8'h55); wr(3'd5, 8'h66);
        wr(3'd2, 8'h20); wr(3'd3, 8'h77); wr(3'd4, 8'h88); wr(3'd5, 8'h99);
        wr(3'd7, 8'h25);
        chk("R10 pulse", dma_go, 1'b1);
        chk("R10 lba", dma_lba, 48'h6655_4499_8877);
        chk("R10 count", dma_count, 16'h0120);
        chk("R10 flags", {dma_write, dma_ext, dma_drive}, 3'b011);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule